// File: doc/BRIEF.md
# RAM, Ports and Interval Timer Peripheral

This peripheral sits on a simple CPU bus and offers three resources: a 128-byte scratch RAM, two 8-bit bidirectional ports, and an 8-bit down-counting interval timer with an active-low interrupt. A chip select qualifies every access. When the RAM select is high, the 7-bit address selects a RAM byte. When it is low, the address selects a register. Read data appears one clock after the access.

Each port has an output latch and a direction register. A direction bit of 1 makes that pin an output. Reading a port's data register returns the latch bit for output pins and the live pin level for input pins. The timer takes its divide ratio from the address used to load it: one of four load addresses starts the count at 1, 8, 64 or 1024 clocks per decrement.

When the count steps from zero it wraps to 0xFF and raises the interrupt. From then on it decrements on every clock, so software can read how far past expiry it is. A new load clears the interrupt, and so does a read of the timer value.

Top module: `rit_top`

## Requirements
- R1: With `chip_sel` and `ram_sel` high, `addr[6:0]` selects one of 128 RAM bytes. A write stores `wdata`. A read returns the byte on `rdata` after the next clock edge. RAM accesses never change the port outputs or port directions.
- R2: With `chip_sel` high and `ram_sel` low, writes go to four registers: address 0x00 is the port A output latch, 0x01 is port A direction, 0x02 is the port B output latch, and 0x03 is port B direction. The latches drive `pa_out`/`pb_out` and the direction registers drive `pa_dir`/`pb_dir`. Reading 0x01 or 0x03 returns the direction value.
- R3: Reading 0x00 or 0x02 returns, bit by bit, the output latch where the direction bit is 1 and the port input pin where it is 0.
- R4: A register write to 0x14, 0x15, 0x16 or 0x17 loads `wdata` as the count and selects 1, 8, 64 or 1024 clocks per decrement (chosen by `addr[1:0]`), restarting the prescaler. After a load of value V at clock edge E with divide ratio D, the count steps from 0 to 0xFF at edge E+D*(V+1).
- R5: A register read of address 0x04 returns the count as it stood after the clock edge before the read edge.
- R6: When the count steps from 0 to 0xFF, `irq_n` goes low after that edge. From then on the count decrements by one on every clock, whatever the divide ratio.
- R7: A timer load clears a pending interrupt after its edge. A read of 0x04 also clears it, unless an underflow happens on the same edge, in which case `irq_n` stays low.
- R8: After reset, `irq_n` is high, both direction registers and both output latches are 0, the divide ratio is 1, and the count is 0xFF.
- R9: With `chip_sel` low, nothing is written: neither RAM nor port registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel | input | 1 | Qualifies a bus access |
| ram_sel | input | 1 | High: access RAM; low: access registers |
| wr_en | input | 1 | High: write; low: read |
| addr | input | 7 | RAM byte index or register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one clock after the read |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_dir | output | 8 | Port A direction, 1 = output |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_dir | output | 8 | Port B direction, 1 = output |
| irq_n | output | 1 | Timer interrupt, active low |

## Verification
The bench loads the timer through each of the four load addresses with small counts. It checks that `irq_n` is still high one clock before the expected underflow edge and low right after it, which tells the four divide ratios apart and catches off-by-one errors in the prescaler. Timer reads taken just before and just after a prescaler tick separate a correct decrement point from an early or late one. Reads after expiry confirm the wrap to 0xFF and the per-clock stepping that follows. Port reads use direction masks that split each byte into output and input halves, so a swapped selection between latch and pin shows up. RAM writes at the edge addresses and at an address that matches a register number show whether RAM and registers stay apart.

// File: rtl/rit_pkg.sv
package rit_pkg;
  localparam int PRE_W = 10;

  typedef enum logic [1:0] {PS_1 = 2'd0, PS_8 = 2'd1, PS_64 = 2'd2, PS_1024 = 2'd3} ps_sel_e;

  // last prescaler value before a decrement tick (ratio - 1)
  function automatic logic [PRE_W-1:0] ps_last(input ps_sel_e sel);
    case (sel)
      PS_1:    ps_last = PRE_W'(0);
      PS_8:    ps_last = PRE_W'(7);
      PS_64:   ps_last = PRE_W'(63);
      default: ps_last = PRE_W'(1023);
    endcase
  endfunction
endpackage

// File: rtl/rit_ram.sv
module rit_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/rit_port.sv
module rit_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_latch,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rd_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_latch) latch_q <= wdata;
      if (wr_dir)   dir_q   <= wdata;
    end
  end

  assign rd_val = (latch_q & dir_q) | (pin_in & ~dir_q);

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_dir |=> $stable(dir_q)); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_latch |=> $stable(latch_q)); // R2
endmodule

// File: rtl/rit_timer.sv
module rit_timer
  import rit_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [1:0]    load_sel,
  input  logic [CW-1:0] load_val,
  input  logic          rd_ack,
  output logic [CW-1:0] count_q,
  output logic          irq_n
);
  ps_sel_e          ps_q;
  logic [PRE_W-1:0] pre_q;
  logic             expired_q;
  logic             tick;
  logic             under;

  assign tick  = expired_q || (pre_q == ps_last(ps_q));
  assign under = tick && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '1;
      pre_q     <= '0;
      ps_q      <= PS_1;
      expired_q <= 1'b0;
      irq_n     <= 1'b1;
    end else if (load) begin
      count_q   <= load_val;
      pre_q     <= '0;
      ps_q      <= ps_sel_e'(load_sel);
      expired_q <= 1'b0;
      irq_n     <= 1'b1;
    end else begin
      if (expired_q || tick) pre_q <= '0;
      else                   pre_q <= pre_q + PRE_W'(1);
      if (tick) count_q <= count_q - CW'(1);
      if (under) begin
        expired_q <= 1'b1;
        irq_n     <= 1'b0;
      end else if (rd_ack) begin
        irq_n     <= 1'b1;
      end
    end
  end

  AST_LOAD_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
    load |=> irq_n); // R7
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!load && under) |=> (!irq_n && count_q == '1)); // R6
  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && expired_q) |=> (count_q == CW'($past(count_q) - CW'(1)))); // R6
  AST_PRESCALE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(count_q)); // R4
endmodule

// File: rtl/rit_top.sv
module rit_top #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_sel,
  input  logic          ram_sel,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_dir,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_dir,
  output logic          irq_n
);
  localparam int NPORT = 2;
  localparam logic [AW-1:0] TMR_RD_ADDR = AW'(4);
  localparam logic [AW-1:0] TMR_LD_BASE = AW'(20);

  logic ram_acc, reg_wr, reg_rd, tmr_load, tmr_rd;
  logic [DW-1:0] ram_q, reg_q, cnt;
  logic ram_pick_q;

  logic [NPORT-1:0][DW-1:0] p_in, p_latch, p_dir, p_rd;

  assign ram_acc  = chip_sel && ram_sel;
  assign reg_wr   = chip_sel && !ram_sel && wr_en;
  assign reg_rd   = chip_sel && !ram_sel && !wr_en;
  assign tmr_load = reg_wr && (addr[AW-1:2] == TMR_LD_BASE[AW-1:2]);
  assign tmr_rd   = reg_rd && (addr == TMR_RD_ADDR);

  assign p_in = {pb_in, pa_in};

  rit_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(ram_acc && wr_en), .re(ram_acc && !wr_en),
    .addr(addr), .wdata(wdata), .q(ram_q)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    rit_port #(.W(DW)) u_port (
      .clk(clk), .rst(rst),
      .wr_latch(reg_wr && (addr == AW'(2*g))),
      .wr_dir(reg_wr && (addr == AW'(2*g + 1))),
      .wdata(wdata), .pin_in(p_in[g]),
      .latch_q(p_latch[g]), .dir_q(p_dir[g]), .rd_val(p_rd[g])
    );
  end

  assign pa_out = p_latch[0];
  assign pa_dir = p_dir[0];
  assign pb_out = p_latch[1];
  assign pb_dir = p_dir[1];

  rit_timer #(.CW(DW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_sel(addr[1:0]),
    .load_val(wdata), .rd_ack(tmr_rd), .count_q(cnt), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      ram_pick_q <= 1'b0;
    end else if (chip_sel && !wr_en) begin
      ram_pick_q <= ram_sel;
      case (addr)
        AW'(0):      reg_q <= p_rd[0];
        AW'(1):      reg_q <= p_dir[0];
        AW'(2):      reg_q <= p_rd[1];
        AW'(3):      reg_q <= p_dir[1];
        TMR_RD_ADDR: reg_q <= cnt;
        default:     reg_q <= '0;
      endcase
    end
  end

  assign rdata = ram_pick_q ? ram_q : reg_q;

  AST_RAM_KEEPS_PORTS: assert property (@(posedge clk) disable iff (rst)
    ram_acc |=> ($stable(pa_out) && $stable(pb_out) && $stable(pa_dir) && $stable(pb_dir))); // R1
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !chip_sel |=> ($stable(pa_out) && $stable(pb_out) && $stable(pa_dir) && $stable(pb_dir))); // R9
endmodule

// File: tb/rit_top_bench.sv
module rit_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_sel = 1'b0, ram_sel = 1'b0, wr_en = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0, pa_in = '0, pb_in = '0;
  logic [7:0] rdata, pa_out, pa_dir, pb_out, pb_dir;
  logic irq_n;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rit_top u_rit_top (
    .clk(clk), .rst(rst), .chip_sel(chip_sel), .ram_sel(ram_sel), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out),
    .pa_dir(pa_dir), .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir), .irq_n(irq_n)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic bus_wr(input logic cs, input logic ram, input logic [6:0] a, input logic [7:0] d);
    chip_sel = cs; ram_sel = ram; wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    chip_sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic ram, input logic [6:0] a, output logic [7:0] d);
    chip_sel = 1'b1; ram_sel = ram; wr_en = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
    chip_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R8", "irq_n", {7'd0, irq_n}, 8'h01);
    check("R8", "pa_dir", pa_dir, 8'h00);
    check("R8", "pa_out", pa_out, 8'h00);
    check("R8", "pb_dir", pb_dir, 8'h00);
    check("R8", "pb_out", pb_out, 8'h00);
    pa_in = 8'h5A;
    bus_rd(1'b0, 7'h00, d);
    check("R3", "reset port A read", d, 8'h5A);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    bus_wr(1'b1, 1'b0, 7'h01, 8'hF0);
    bus_wr(1'b1, 1'b0, 7'h00, 8'hA5);
    bus_wr(1'b1, 1'b0, 7'h03, 8'h0F);
    bus_wr(1'b1, 1'b0, 7'h02, 8'h96);
    check("R2", "pa_out", pa_out, 8'hA5);
    check("R2", "pa_dir", pa_dir, 8'hF0);
    check("R2", "pb_out", pb_out, 8'h96);
    pa_in = 8'h3C; pb_in = 8'h71;
    bus_rd(1'b0, 7'h00, d);
    check("R3", "port A mixed read", d, 8'hAC);
    bus_rd(1'b0, 7'h02, d);
    check("R3", "port B mixed read", d, 8'h76);
    bus_rd(1'b0, 7'h03, d);
    check("R2", "port B dir read", d, 8'h0F);
  endtask

  task automatic t_ram();
    logic [7:0] d;
    bus_wr(1'b1, 1'b1, 7'h00, 8'h11);
    bus_wr(1'b1, 1'b1, 7'h7F, 8'hEE);
    bus_wr(1'b1, 1'b1, 7'h02, 8'h5C);
    check("R1", "pa_out after RAM write", pa_out, 8'hA5);
    check("R1", "pb_out after RAM write", pb_out, 8'h96);
    bus_rd(1'b1, 7'h00, d);
    check("R1", "RAM[00]", d, 8'h11);
    bus_rd(1'b1, 7'h7F, d);
    check("R1", "RAM[7F]", d, 8'hEE);
    bus_rd(1'b1, 7'h02, d);
    check("R1", "RAM[02]", d, 8'h5C);
    bus_wr(1'b0, 1'b1, 7'h00, 8'h77);
    bus_rd(1'b1, 7'h00, d);
    check("R9", "RAM write without chip select", d, 8'h11);
    bus_wr(1'b0, 1'b0, 7'h00, 8'h00);
    check("R9", "latch write without chip select", pa_out, 8'hA5);
  endtask

  task automatic t_div1();
    logic [7:0] d;
    bus_wr(1'b1, 1'b0, 7'h14, 8'd2);
    repeat (2) @(negedge clk);
    check("R4", "div1 irq before underflow", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    check("R6", "div1 irq at underflow", {7'd0, irq_n}, 8'h00);
    bus_rd(1'b0, 7'h04, d);
    check("R6", "count wrapped", d, 8'hFF);
    check("R7", "irq cleared by count read", {7'd0, irq_n}, 8'h01);
    bus_rd(1'b0, 7'h04, d);
    check("R6", "per-clock step after expiry", d, 8'hFE);
  endtask

  task automatic t_div8();
    bus_wr(1'b1, 1'b0, 7'h15, 8'd3);
    repeat (31) @(negedge clk);
    check("R4", "div8 irq before underflow", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    check("R4", "div8 irq at underflow", {7'd0, irq_n}, 8'h00);
    bus_wr(1'b1, 1'b0, 7'h14, 8'd200);
    check("R7", "irq cleared by load", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_div64();
    logic [7:0] d;
    bus_wr(1'b1, 1'b0, 7'h16, 8'd5);
    repeat (63) @(negedge clk);
    bus_rd(1'b0, 7'h04, d);
    check("R5", "div64 count before tick", d, 8'd5);
    bus_rd(1'b0, 7'h04, d);
    check("R4", "div64 count after tick", d, 8'd4);
  endtask

  task automatic t_div1024();
    bus_wr(1'b1, 1'b0, 7'h17, 8'd1);
    repeat (2047) @(negedge clk);
    check("R4", "div1024 irq before underflow", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    check("R4", "div1024 irq at underflow", {7'd0, irq_n}, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] d;
    bus_wr(1'b1, 1'b0, 7'h14, 8'd1);
    @(negedge clk);
    bus_rd(1'b0, 7'h04, d);
    check("R5", "count read on underflow edge", d, 8'h00);
    check("R7", "underflow beats read clear", {7'd0, irq_n}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ports();
    t_ram();
    t_div1();
    t_div8();
    t_div64();
    t_div1024();
    t_race();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule